// File: doc/BRIEF.md
# Programmable Sub-Audio Tone Generator

This block produces a continuous low-frequency signalling tone as a stream of unsigned digital samples, clocked directly from the crystal-derived system clock. A 13-bit divisor `A` sets the tone so that one full tone cycle lasts exactly `16 × A` clocks: the clock is divided by `A` to form a step strobe, and each strobe moves a 4-bit phase index one step through a 16-point sine. The sample value 128 is the bias (silent) level.

The divisor and a silence flag are written as a two-byte word over a byte-wide control port. The upper byte comes first and is only held aside. The lower byte commits both bytes at once and restarts the waveform from its first step, so the output never runs on half of a new word. The committed divisor is also driven out unchanged as the target value for a receive-side predictive tone matcher. This keeps the transmitted tone and the predicted tone identical.

The output is held at the bias level in three cases: the silence flag is set, the divisor is zero (power-save), or both the transmit enable and the fast-detect enable are low.

Top module: `sub_tone_gen`

## Requirements
- R1: After reset, `sample` is 128, `tone_on` is 0 and `match_div` is 0.
- R2: A word is written as two byte writes. The upper byte (`cfg_lo`=0) carries divisor bits 12..8 in its bits 4..0 and the silence flag in its bit 7; its bits 6..5 are ignored. The lower byte (`cfg_lo`=1) carries divisor bits 7..0. The lower-byte write commits the whole word, and `match_div` shows the committed divisor from the next cycle on.
- R3: An upper-byte write with no lower-byte write after it changes neither `sample`, `tone_on` nor `match_div`.
- R4: While running, the phase index k (0..15) advances by one every A clocks, and `sample` equals 128 + round(127·sin(2πk/16)), so the tone period is 16·A clocks. For example, A = 2520 gives 40320 clocks, which is 100 Hz from a 4.032 MHz clock.
- R5: While the committed silence flag is 1, `sample` is 128 and `tone_on` is 0, whatever the divisor is.
- R6: While the committed divisor is 0, `sample` is 128 and `tone_on` is 0.
- R7: While `tx_en` and `fast_en` are both 0, `sample` is 128 and `tone_on` is 0. Either enable alone is enough to run the tone.
- R8: A lower-byte write restarts the waveform. In the cycle after the commit the phase index is 0, and the first step comes A clocks after the commit edge.
- R9: `match_div` shows the committed divisor whatever the state of the enables and the silence flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also sets the tone timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| fast_en | input | 1 | Fast receive-detector enable; also keeps the generator running |
| cfg_wr | input | 1 | Byte write strobe for the frequency word |
| cfg_lo | input | 1 | 0 = upper byte (held aside), 1 = lower byte (commits the word) |
| cfg_byte | input | 8 | Byte being written |
| sample | output | 8 | Unsigned tone sample; 128 is the bias level |
| tone_on | output | 1 | 1 while a tone is being produced |
| match_div | output | 13 | Committed divisor, for the receive-side matcher |

## Verification
Every divisor from 1 to 7 is run for two full tone cycles and the sample is compared on every clock. This tells apart a divide by A from a divide by A±1, and shows a wrong sine entry or a wrong step order. A 100 Hz word (A = 2520) is timed between two entries into the same phase, which confirms the 16·A period at a realistic size. The remaining patterns are: silence with a nonzero divisor, a zero divisor, both enables low, and a lone upper-byte write in the middle of a tone. Together they separate the three idle causes from one another and from the commit rule. A re-commit in the middle of a tone shows the restart, and the `fast_en`-only run shows that either enable starts the tone.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int DIV_W = 13;
  localparam int PH_W  = 4;
  localparam int SMP_W = 8;
  localparam logic [SMP_W-1:0] MID = SMP_W'(128);

  typedef struct packed {
    logic             mute;
    logic [DIV_W-1:0] div;
  } freq_cfg_t;

  // 16-point sine, mid-scale 128, amplitude 127
  function automatic logic [SMP_W-1:0] sine_pt(input logic [PH_W-1:0] k);
    logic [SMP_W-1:0] v;
    case (k)
      4'd0:  v = 8'd128;
      4'd1:  v = 8'd177;
      4'd2:  v = 8'd218;
      4'd3:  v = 8'd245;
      4'd4:  v = 8'd255;
      4'd5:  v = 8'd245;
      4'd6:  v = 8'd218;
      4'd7:  v = 8'd177;
      4'd8:  v = 8'd128;
      4'd9:  v = 8'd79;
      4'd10: v = 8'd38;
      4'd11: v = 8'd11;
      4'd12: v = 8'd1;
      4'd13: v = 8'd11;
      4'd14: v = 8'd38;
      default: v = 8'd79;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/stg_freq_reg.sv
module stg_freq_reg
  import stg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             lo,
  input  logic [7:0]       wbyte,
  output freq_cfg_t        cfg,
  output logic             load
);
  localparam int HI_DIV_W = DIV_W - 8;

  logic [7:0] hi_q, hi_d;
  freq_cfg_t  cfg_q, cfg_d;

  assign load = wr & lo;

  always_comb begin
    hi_d  = hi_q;
    cfg_d = cfg_q;
    if (wr && !lo) hi_d = wbyte;
    if (load) begin
      cfg_d.mute = hi_q[7];
      cfg_d.div  = {hi_q[HI_DIV_W-1:0], wbyte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      cfg_q <= '0;
    end else begin
      hi_q  <= hi_d;
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/stg_step_div.sv
module stg_step_div
  import stg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             strobe,
  output logic [DIV_W-1:0] cnt
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == (div - ONE));
  assign strobe = run & ~load & at_end;

  always_comb begin
    if (!run || load)  cnt_d = '0;
    else if (at_end)   cnt_d = '0;
    else               cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/stg_wave.sv
module stg_wave
  import stg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             strobe,
  output logic [PH_W-1:0]  phase,
  output logic [SMP_W-1:0] sample
);
  localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;

  assign ph_en = strobe | load | ~run;

  always_comb begin
    if (!run || load) ph_d = '0;
    else              ph_d = ph_q + PH_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign phase  = ph_q;
  assign sample = run ? sine_pt(ph_q) : MID;
endmodule

// File: rtl/sub_tone_gen.sv
module sub_tone_gen
  import stg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             fast_en,
  input  logic             cfg_wr,
  input  logic             cfg_lo,
  input  logic [7:0]       cfg_byte,
  output logic [SMP_W-1:0] sample,
  output logic             tone_on,
  output logic [DIV_W-1:0] match_div
);
  freq_cfg_t        cfg;
  logic             load;
  logic             run;
  logic             strobe;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  phase;

  stg_freq_reg u_freq (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .lo(cfg_lo),
    .wbyte(cfg_byte), .cfg(cfg), .load(load)
  );

  assign run = (tx_en | fast_en) & ~cfg.mute & (cfg.div != '0);

  stg_step_div u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .div(cfg.div), .strobe(strobe), .cnt(cnt)
  );

  stg_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .strobe(strobe), .phase(phase), .sample(sample)
  );

  assign tone_on   = run;
  assign match_div = cfg.div;
endmodule

// File: rtl/stg_chk.sv
module stg_chk
  import stg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             fast_en,
  input logic             cfg_wr,
  input logic             cfg_lo,
  input logic [7:0]       cfg_byte,
  input logic [SMP_W-1:0] sample,
  input logic             tone_on,
  input logic [DIV_W-1:0] match_div,
  input freq_cfg_t        cfg,
  input logic [DIV_W-1:0] cnt,
  input logic [PH_W-1:0]  phase
);
  // R5
  mute_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mute |-> (sample == MID && !tone_on));

  // R6
  zero_div_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_div == '0) |-> (sample == MID));

  // R7
  no_enable_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !fast_en) |-> (sample == MID));

  // R2
  commit_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_lo) |=> (match_div[7:0] == $past(cfg_byte)));

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_lo) |=> ($stable(match_div) && $stable(cfg.mute)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_lo) |=> (cnt == '0 && phase == '0));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_on |-> (cnt < match_div));
endmodule

bind sub_tone_gen stg_chk u_stg_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fast_en(fast_en),
  .cfg_wr(cfg_wr), .cfg_lo(cfg_lo), .cfg_byte(cfg_byte),
  .sample(sample), .tone_on(tone_on), .match_div(match_div),
  .cfg(cfg), .cnt(cnt), .phase(phase)
);

// File: tb/test_sub_tone_gen.sv
`timescale 1ns/1ps
module test_sub_tone_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en, fast_en, cfg_wr, cfg_lo;
  logic [7:0]  cfg_byte;
  logic [7:0]  sample;
  logic        tone_on;
  logic [12:0] match_div;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  sub_tone_gen i_sub_tone_gen (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fast_en(fast_en),
    .cfg_wr(cfg_wr), .cfg_lo(cfg_lo), .cfg_byte(cfg_byte),
    .sample(sample), .tone_on(tone_on), .match_div(match_div)
  );

  function automatic int exp_smp(int k);
    return $rtoi(127.0 * $sin(2.0 * 3.14159265358979 * (k % 16) / 16.0) + 128.5);
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_byte(bit lo, logic [7:0] b);
    cfg_wr = 1'b1; cfg_lo = lo; cfg_byte = b;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_lo = 1'b0; cfg_byte = 8'h00;
  endtask

  // leaves the bench at the negedge right after the commit edge (n = 0)
  task automatic write_word(bit mute, int a);
    put_byte(1'b0, {mute, 2'b00, 5'(a >> 8)});
    put_byte(1'b1, 8'(a));
  endtask

  task automatic run_tone(string tag, int a, int cycles);
    for (int n = 0; n < cycles; n++) begin
      check(tag, sample, exp_smp(n / a));
      @(negedge clk);
    end
  endtask

  task automatic hold_bias(string tag, int cycles);
    for (int n = 0; n < cycles; n++) begin
      check(tag, sample, 128);
      check(tag, tone_on, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; fast_en = 1'b0;
    cfg_wr = 1'b0; cfg_lo = 1'b0; cfg_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sample", sample, 128);
    check("R1 tone_on", tone_on, 0);
    check("R1 match_div", match_div, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sample after release", sample, 128);

    // R4 sweep of small divisors, transmit enable only
    tx_en = 1'b1;
    for (int a = 1; a <= 7; a++) begin
      write_word(1'b0, a);
      check("R2 match_div", match_div, a);
      check("R4 tone_on", tone_on, 1);
      run_tone("R4 sweep", a, 32 * a);
    end

    // R2 upper-byte bits, with junk in ignored bits 6..5
    put_byte(1'b0, 8'h6A);
    put_byte(1'b1, 8'h5C);
    check("R2 wide divisor", match_div, 13'h0A5C);
    check("R2 tone_on", tone_on, 1);

    // R7 fast-detect enable alone runs the tone
    tx_en = 1'b0; fast_en = 1'b1;
    write_word(1'b0, 3);
    run_tone("R7 fast only", 3, 96);

    // R8 recommit in mid-tone restarts at phase 0
    run_tone("R8 pre", 5, 0);
    write_word(1'b0, 5);
    run_tone("R8 lead", 5, 13);
    write_word(1'b0, 5);
    run_tone("R8 restart", 5, 80);

    // R3 lone upper byte with silence flag and other bits mid-tone
    tx_en = 1'b1; fast_en = 1'b0;
    write_word(1'b0, 4);
    run_tone("R3 lead", 4, 6);
    put_byte(1'b0, 8'h9F);
    check("R3 match_div", match_div, 4);
    check("R3 tone_on", tone_on, 1);
    for (int n = 7; n < 70; n++) begin
      check("R3 tone continues", sample, exp_smp(n / 4));
      @(negedge clk);
    end

    // R5 silence flag with nonzero divisor
    write_word(1'b1, 5);
    hold_bias("R5 mute", 60);
    check("R9 match under mute", match_div, 5);

    // R6 zero divisor
    write_word(1'b0, 0);
    hold_bias("R6 zero div", 40);

    // R7 both enables low
    write_word(1'b0, 3);
    tx_en = 1'b0; fast_en = 1'b0;
    @(negedge clk);
    hold_bias("R7 no enable", 40);
    check("R9 match disabled", match_div, 3);
    tx_en = 1'b1;
    run_tone("R7 resume", 3, 48);

    // R4 100 Hz word: period 16*2520 clocks
    begin
      int n, first, second, prev;
      write_word(1'b0, 2520);
      n = 0; first = -1; second = -1; prev = sample;
      while (second < 0 && n < 90000) begin
        @(negedge clk); n++;
        if (sample == 177 && prev == 128) begin
          if (first < 0) first = n; else second = n;
        end
        prev = sample;
      end
      check("R4 first step at A", first, 2520);
      check("R4 period 40320", second - first, 40320);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule